// File: doc/BRIEF.md
# ADC Parallel Result Read Port

This block sits between a successive-approximation conversion controller and a shared parallel host bus. It keeps the most recent 12-bit conversion result in an output register. The result is shown on a 16-bit data vector together with an output enable. The pair stands in for a bank of three-state drivers: when the enable is low, the bus belongs to someone else and the data vector is held at zero.

The controller raises a one-cycle load strobe with the new result near the end of each conversion, while its BUSY line is still low. When BUSY rises, the host can latch the data. The host reads by pulling chip select low with read/convert high. A narrow-access input switches between a full 16-bit word and a byte-wide read, and a byte-select input picks which half of the word is returned.

The result is left-justified in the word, so its MSB is on bus line 15 and the four lowest lines are zero. A read made while a conversion is running returns the result of the previous conversion, because the register changes only on the strobe.

Top module: `adc_bus_reader`

## Requirements
- R1: `bus_oe` is low in every cycle in which `cs_n` is high or `rd_cnv` is low, whatever the level of `busy_n`.
- R2: `bus_oe` is high in the same cycle in which `cs_n` is low and `rd_cnv` is high, whether `busy_n` is high or low. This includes the case where `cs_n` stays low and only `rd_cnv` toggles.
- R3: With `narrow_en` low and the bus enabled, `bus_data` equals the stored result shifted left by four, so result bit 11 is on line 15 and lines 3..0 are 0. `byte_sel` has no effect in this mode.
- R4: With `narrow_en` high, `byte_sel` low and the bus enabled, `bus_data[15:8]` carries the justified word's bits 15..8 (result bits 11..4), and `bus_data[7:0]` is 0.
- R5: With `narrow_en` high, `byte_sel` high and the bus enabled, `bus_data[15:8]` carries the justified word's bits 7..0 (result bits 3..0 followed by four zeros), and `bus_data[7:0]` is 0.
- R6: Whenever `bus_oe` is low, `bus_data` is all zeros.
- R7: After reset, the stored result is zero. A read before any load returns 0.
- R8: When `ld_stb` is high at a rising clock edge, `ld_val` is stored, and reads show it from that edge on. Loads are issued only while `busy_n` is low.
- R9: Without `ld_stb`, the stored result does not change. A read while `busy_n` is low returns the previously loaded result.
- R10: Changes on `ld_val` while `ld_stb` is low have no effect on what a read returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_cnv | input | 1 | High selects read; low is the convert phase |
| narrow_en | input | 1 | High selects byte-wide access |
| byte_sel | input | 1 | In byte mode: low = upper byte, high = lower byte |
| busy_n | input | 1 | Conversion in progress when low |
| ld_stb | input | 1 | One-cycle strobe that loads a new result |
| ld_val | input | 12 | New conversion result, two's complement |
| bus_data | output | 16 | Data lines, zero when not enabled |
| bus_oe | output | 1 | Enable standing in for the three-state drivers |

## Verification
The bench walks every combination of chip select, read/convert and BUSY, and checks both the enable and the zeroed data. A decoder that looked at BUSY, or one that treated the enable as active high, would drive the bus while it is deselected.

Reads in the middle of a conversion are made while a different value waits on `ld_val`. A register that followed the input instead of the strobe would leak the new value early.

Patterns at the extremes (0x800, 0x7FF, 0xFFF, 0x000, 0xABC) are read in word mode and in both byte halves. These catch a right-justified word, swapped byte lanes, or a low lane that is not forced to zero.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;

  // What the bus shows in the current cycle.
  typedef enum logic [1:0] {
    VIEW_OFF  = 2'd0,
    VIEW_WORD = 2'd1,
    VIEW_HIGH = 2'd2,
    VIEW_LOW  = 2'd3
  } view_e;

endpackage

// File: rtl/adc_result_hold.sv
module adc_result_hold #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_stb,
  input  logic [RES_W-1:0] ld_val,
  input  logic             conv_busy,
  output logic [RES_W-1:0] result
);

  logic [RES_W-1:0] result_q;
  logic             load_evt;

  assign load_evt = ld_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        result_q <= '0;
    else if (load_evt) result_q <= ld_val;
  end

  assign result = result_q;

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (result == $past(ld_val))); // R8

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(result)); // R9

  AST_LOAD_IN_CONVERSION: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> conv_busy); // R8

endmodule

// File: rtl/adc_bus_decode.sv
module adc_bus_decode
  import adc_bus_pkg::*;
(
  input  logic  cs_n,
  input  logic  rd_cnv,
  input  logic  narrow_en,
  input  logic  byte_sel,
  output view_e view,
  output logic  drive_en
);

  logic selected;

  // The bus is driven only in the read phase while the chip is selected.
  assign selected = !cs_n && rd_cnv;
  assign drive_en = selected;

  always_comb begin
    if (!selected)      view = VIEW_OFF;
    else if (!narrow_en) view = VIEW_WORD;
    else if (byte_sel)   view = VIEW_LOW;
    else                 view = VIEW_HIGH;
  end

endmodule

// File: rtl/adc_bus_format.sv
module adc_bus_format
  import adc_bus_pkg::*;
#(
  parameter int RES_W  = 12,
  parameter int BUS_W  = 16,
  parameter int LANE_W = 8
) (
  input  view_e            view,
  input  logic [RES_W-1:0] result,
  output logic [BUS_W-1:0] bus_data
);

  localparam int PAD_W = BUS_W - RES_W;

  // Put the result at the top of the word; the low pad bits are zero.
  function automatic logic [BUS_W-1:0] justify(input logic [RES_W-1:0] r);
    return BUS_W'(r) << PAD_W;
  endfunction

  // Put one lane of the word on the top lane; all other lines are zero.
  function automatic logic [BUS_W-1:0] lane_up(input logic [LANE_W-1:0] b);
    return BUS_W'(b) << (BUS_W - LANE_W);
  endfunction

  logic [BUS_W-1:0]  word;
  logic [LANE_W-1:0] hi_lane;
  logic [LANE_W-1:0] lo_lane;

  assign word    = justify(result);
  assign hi_lane = word[BUS_W-1 -: LANE_W];
  assign lo_lane = word[LANE_W-1:0];

  always_comb begin
    unique case (view)
      VIEW_WORD: bus_data = word;
      VIEW_HIGH: bus_data = lane_up(hi_lane);
      VIEW_LOW:  bus_data = lane_up(lo_lane);
      default:   bus_data = '0;
    endcase
  end

endmodule

// File: rtl/adc_bus_reader.sv
module adc_bus_reader
  import adc_bus_pkg::*;
#(
  parameter int RES_W  = 12,
  parameter int BUS_W  = 16,
  parameter int LANE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rd_cnv,
  input  logic             narrow_en,
  input  logic             byte_sel,
  input  logic             busy_n,
  input  logic             ld_stb,
  input  logic [RES_W-1:0] ld_val,
  output logic [BUS_W-1:0] bus_data,
  output logic             bus_oe
);

  logic [RES_W-1:0] stored;
  view_e            view;
  logic             conv_busy;

  assign conv_busy = !busy_n;

  adc_result_hold #(.RES_W(RES_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_stb    (ld_stb),
    .ld_val    (ld_val),
    .conv_busy (conv_busy),
    .result    (stored)
  );

  adc_bus_decode u_decode (
    .cs_n      (cs_n),
    .rd_cnv    (rd_cnv),
    .narrow_en (narrow_en),
    .byte_sel  (byte_sel),
    .view      (view),
    .drive_en  (bus_oe)
  );

  adc_bus_format #(.RES_W(RES_W), .BUS_W(BUS_W), .LANE_W(LANE_W)) u_format (
    .view     (view),
    .result   (stored),
    .bus_data (bus_data)
  );

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || !rd_cnv) |-> (!bus_oe && (bus_data == '0))); // R1

  AST_IDLE_LINES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_data == '0)); // R6

  AST_WORD_TRACKS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && !narrow_en) |-> (bus_data[BUS_W-1 -: RES_W] == stored)); // R3

  AST_BYTE_LOW_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && narrow_en) |-> (bus_data[LANE_W-1:0] == '0)); // R4

endmodule

// File: tb/adc_bus_reader_bench.sv
module adc_bus_reader_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        rd_cnv = 1'b0;
  logic        narrow_en = 1'b0;
  logic        byte_sel = 1'b0;
  logic        busy_n = 1'b1;
  logic        ld_stb = 1'b0;
  logic [11:0] ld_val = '0;
  logic [15:0] bus_data;
  logic        bus_oe;

  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 1'b0;
  logic [11:0] shadow = '0;

  logic [16:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;  // 50 MHz

  adc_bus_reader u_adc_bus_reader (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_cnv(rd_cnv),
    .narrow_en(narrow_en), .byte_sel(byte_sel), .busy_n(busy_n),
    .ld_stb(ld_stb), .ld_val(ld_val), .bus_data(bus_data), .bus_oe(bus_oe)
  );

  // Expected bus from the requirements, written arithmetically.
  function automatic logic [16:0] expect_bus(input logic c, input logic r,
                                             input logic nw, input logic bs,
                                             input logic [11:0] res);
    int w;
    int d;
    if (c || !r) return 17'h0;                 // R1, R6
    w = int'(res) * 16;                        // R3
    if (!nw)     d = w;
    else if (bs) d = (w % 256) * 256;          // R5
    else         d = (w / 256) * 256;          // R4
    return {1'b1, 16'(d)};
  endfunction

  task automatic apply(input logic c, input logic r, input logic nw,
                       input logic bs, input logic bz, input string tag);
    cs_n = c; rd_cnv = r; narrow_en = nw; byte_sel = bs; busy_n = bz;
    exp_q.push_back(expect_bus(c, r, nw, bs, shadow));
    tag_q.push_back(tag);
    @(posedge clk); #1;
  endtask

  task automatic load(input logic [11:0] v);
    ld_stb = 1'b1; ld_val = v;
    @(posedge clk); #1;
    ld_stb = 1'b0;
    shadow = v;                                // R8
  endtask

  // Monitor: compare at the falling edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [16:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_vec++;
      if ({bus_oe, bus_data} !== e) begin
        n_bad++;
        $display("FAIL %s: oe/data got %0b/%h expected %0b/%h",
                 t, bus_oe, bus_data, e[16], e[15:0]);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [11:0] pats[5];
    pats = '{12'h800, 12'h7FF, 12'hFFF, 12'h000, 12'hABC};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    apply(0, 1, 0, 0, 1, "R7 reset read");
    apply(1, 0, 0, 0, 1, "R1 idle");

    busy_n = 1'b0;
    load(12'hABC);
    busy_n = 1'b1;

    // Full truth table of cs_n, rd_cnv and busy_n.
    for (int k = 0; k < 8; k++) begin
      apply(k[2], k[1], 0, 0, k[0], (k[2] || !k[1]) ? "R1 R6 deselect" : "R2 R3 select");
    end
    // cs_n held low, rd_cnv toggling
    apply(0, 0, 0, 0, 1, "R1 tied cs low");
    apply(0, 1, 0, 0, 1, "R2 tied cs low");
    apply(0, 1, 0, 1, 1, "R3 byte_sel ignored");
    apply(0, 1, 1, 0, 1, "R4 upper byte");
    apply(0, 1, 1, 1, 1, "R5 lower byte");
    apply(1, 1, 1, 1, 1, "R6 byte mode deselected");

    // Conversion in progress: new value waits on ld_val without strobe.
    busy_n = 1'b0;
    ld_val = 12'h123;
    apply(0, 0, 0, 0, 0, "R1 convert phase");
    apply(0, 1, 0, 0, 0, "R9 mid-conversion read");
    apply(0, 1, 1, 1, 0, "R10 no strobe no effect");
    ld_val = 12'h5A5;
    apply(0, 1, 1, 0, 0, "R10 no strobe no effect");
    load(12'h123);
    apply(0, 1, 0, 0, 0, "R8 loaded before busy release");
    apply(0, 1, 0, 0, 1, "R8 after busy release");

    foreach (pats[i]) begin
      busy_n = 1'b0;
      load(pats[i]);
      apply(0, 1, 0, 0, 1, "R3 pattern word");
      apply(0, 1, 1, 0, 1, "R4 pattern upper");
      apply(0, 1, 1, 1, 1, "R5 pattern lower");
      apply(1, 1, 0, 0, 1, "R6 pattern deselect");
    end

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule